// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is a small timekeeping peripheral. It runs on the fast system clock and advances on a one-cycle enable that marks each tick of a 32768 Hz slow clock. It holds a free-running real-time count behind a programmable divider, a periodic interval timer that reloads itself, and an alarm that compares against an absolute count value. Events from these parts gather in a status register. Reading that register clears it. A mask decides which pending events drive a single level interrupt.

Software reaches the block through a simple synchronous register bus with a select, a write flag, a 3-bit word address and 32-bit data. Writes take effect at the clock edge. Read data is combinational from the registers. A read of the status register clears the pending bits at the edge that ends the read cycle. A periodic tick uses the interval timer. A one-shot event writes the alarm with the current count plus a delta of at least two.

Top module: `slow_sys_timer`

## Requirements
- R1: The real-time count is CNT_W bits (20 by default), steps by exactly +1 at each advance and goes from all ones to zero.
- R2: After reset the divider field (address 0, bits 15:0) reads 32768, so the count advances once per 32768 slow ticks. Count, status, mask, period and alarm all read 0.
- R3: Writing a value P to address 0 restarts the divider. The count then advances on every P-th slow tick after the write, and a P of 0 or 1 advances it on every tick.
- R4: Writing a nonzero P to the period register (address 1) makes status bit 0 set on every P-th slow tick after the write, reloading each time. A period of 0 stops it.
- R5: Status bit 3 sets at the advance that makes the count equal to the alarm register (address 2). An alarm equal to the count at the moment it is written fires only after a full wrap.
- R6: Status bit 2 sets at every count advance. Status bit 1 is reserved for a watchdog overflow and always reads 0 here.
- R7: A read of address 4 returns the pending status bits and clears them. An event that arrives in the same cycle as the read stays pending.
- R8: Writing ones to address 5 sets those mask bits, and writing ones to address 6 clears them. Address 7 reads the mask.
- R9: The output irq is high exactly when some status bit and its mask bit are both set.
- R10: A count read (address 3) returns a value held in a register, so two back-to-back reads with no tick between them return equal values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe per slow-clock tick |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high |
| irq | output | 1 | Level interrupt, masked status |

## Verification
The bench uses an 8-bit counter. This lets it walk the count through a complete wrap and place the alarm at every seventeenth value. Each of these cases shows whether the match fires on the exact advance, including the case of an alarm equal to the current count, which must wait 256 ticks. Divider values 1 to 6 and interval periods 1 to 6 are each probed one tick before and at the expected event, which separates off-by-one errors from correct reloads. The reset divider is checked over the full 32768 ticks. Status reads placed on the same cycle as an advance show whether a clear can swallow a new event.

// File: rtl/sst_pkg.sv
// Shared definitions for the slow-clock system timer.
// Assumes a word-addressed bus with a 3-bit address.
package sst_pkg;
    typedef enum logic [2:0] {
        A_MODE   = 3'd0,
        A_PERIOD = 3'd1,
        A_ALARM  = 3'd2,
        A_COUNT  = 3'd3,
        A_STATUS = 3'd4,
        A_IEN    = 3'd5,
        A_IDIS   = 3'd6,
        A_IMASK  = 3'd7
    } sst_addr_e;

    localparam int ST_W    = 4;
    localparam int BIT_PIT = 0;
    localparam int BIT_WDG = 1;
    localparam int BIT_INC = 2;
    localparam int BIT_ALM = 3;
endpackage

// File: rtl/sst_rt_counter.sv
// Divider plus free-running real-time count.
// Assumes tick_en is a one-cycle strobe per slow tick. A divider value of 0
// behaves like 1. A write to the divider restarts the division.
module sst_rt_counter #(
    parameter int CNT_W   = 20,
    parameter int PRE_W   = 16,
    parameter int PRE_RST = 32768
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             pre_wr,
    input  logic [PRE_W-1:0] pre_wdata,
    output logic [PRE_W-1:0] pre_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next,
    output logic             adv_o
);
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] last_step;

    // Terminal value of the divider, with 0 treated as 1
    always_comb last_step = (pre_q == '0) ? '0 : pre_q - 1'b1;

    assign adv_o    = tick_en && !pre_wr && (div_q >= last_step);
    assign cnt_next = cnt_q + 1'b1;

    // Divider register and its phase counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= PRE_W'(PRE_RST);
            div_q <= '0;
        end else if (pre_wr) begin
            pre_q <= pre_wdata;
            div_q <= '0;
        end else if (adv_o) begin
            div_q <= '0;
        end else if (tick_en) begin
            div_q <= div_q + 1'b1;
        end
    end

    // Real-time count, wraps naturally at all ones
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (adv_o) cnt_q <= cnt_next;
    end
endmodule

// File: rtl/sst_interval.sv
// Periodic interval timer counting slow ticks down from a reload value.
// Assumes a write loads both the period and the down-counter. A period of 0 halts it.
module sst_interval #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             per_wr,
    input  logic [PER_W-1:0] per_wdata,
    output logic [PER_W-1:0] per_q,
    output logic             expire_o
);
    logic [PER_W-1:0] down_q;

    assign expire_o = tick_en && !per_wr && (per_q != '0) && (down_q == PER_W'(1));

    // Period register and down-counter with reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q  <= '0;
            down_q <= '0;
        end else if (per_wr) begin
            per_q  <= per_wdata;
            down_q <= per_wdata;
        end else if (tick_en && per_q != '0) begin
            down_q <= (down_q == PER_W'(1)) ? per_q : down_q - 1'b1;
        end
    end
endmodule

// File: rtl/sst_alarm.sv
// Absolute alarm: flags the advance whose new count equals the stored value.
// Assumes cnt_next is the count that adv loads at this edge.
module sst_alarm #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alm_wr,
    input  logic [CNT_W-1:0] alm_wdata,
    input  logic             adv,
    input  logic [CNT_W-1:0] cnt_next,
    output logic [CNT_W-1:0] alm_q,
    output logic             hit_o
);
    assign hit_o = adv && (cnt_next == alm_q);

    // Alarm value register
    always_ff @(posedge clk) begin
        if (!rst_n)      alm_q <= '0;
        else if (alm_wr) alm_q <= alm_wdata;
    end
endmodule

// File: rtl/sst_irq_status.sv
// Sticky status bits with clear-on-read, plus the set/clear interrupt mask.
// Assumes an event in the read cycle survives the clear.
module sst_irq_status
    import sst_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] events,
    input  logic            rd_clr,
    input  logic            en_wr,
    input  logic            dis_wr,
    input  logic [ST_W-1:0] wmask,
    output logic [ST_W-1:0] st_q,
    output logic [ST_W-1:0] mask_q,
    output logic            irq
);
    // Pending bits: clear on read, new events always win
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (rd_clr ? '0 : st_q) | events;
    end

    // Mask updated by write-one-to-set and write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= (mask_q | (en_wr ? wmask : '0)) & ~(dis_wr ? wmask : '0);
    end

    assign irq = |(st_q & mask_q);
endmodule

// File: rtl/slow_sys_timer.sv
// Top of the slow-clock system timer: register decode, read mux and event wiring.
// Assumes DATA_W covers the widest register. Read data is combinational.
module slow_sys_timer
    import sst_pkg::*;
#(
    parameter int CNT_W   = 20,
    parameter int PRE_W   = 16,
    parameter int PER_W   = 16,
    parameter int PRE_RST = 32768,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic             wr_en, rd_en;
    logic [PRE_W-1:0] pre_q;
    logic [PER_W-1:0] per_q;
    logic [CNT_W-1:0] cnt_q, cnt_next, alm_q;
    logic             adv, expire, hit;
    logic [ST_W-1:0]  events, st_q, mask_q;
    logic             unused_ok;

    assign wr_en     = bus_sel && bus_wr;
    assign rd_en     = bus_sel && !bus_wr;
    assign unused_ok = &{1'b0, bus_wdata};

    sst_rt_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .pre_wr(wr_en && bus_addr == A_MODE), .pre_wdata(bus_wdata[PRE_W-1:0]),
        .pre_q(pre_q), .cnt_q(cnt_q), .cnt_next(cnt_next), .adv_o(adv)
    );

    sst_interval #(.PER_W(PER_W)) u_pit (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .per_wr(wr_en && bus_addr == A_PERIOD), .per_wdata(bus_wdata[PER_W-1:0]),
        .per_q(per_q), .expire_o(expire)
    );

    sst_alarm #(.CNT_W(CNT_W)) u_alm (
        .clk(clk), .rst_n(rst_n),
        .alm_wr(wr_en && bus_addr == A_ALARM), .alm_wdata(bus_wdata[CNT_W-1:0]),
        .adv(adv), .cnt_next(cnt_next), .alm_q(alm_q), .hit_o(hit)
    );

    // Event vector in status bit order, watchdog position tied low
    always_comb begin
        events          = '0;
        events[BIT_PIT] = expire;
        events[BIT_WDG] = 1'b0;
        events[BIT_INC] = adv;
        events[BIT_ALM] = hit;
    end

    sst_irq_status u_st (
        .clk(clk), .rst_n(rst_n), .events(events),
        .rd_clr(rd_en && bus_addr == A_STATUS),
        .en_wr(wr_en && bus_addr == A_IEN), .dis_wr(wr_en && bus_addr == A_IDIS),
        .wmask(bus_wdata[ST_W-1:0]), .st_q(st_q), .mask_q(mask_q), .irq(irq)
    );

    // Read data selection, zero-extended
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE:   bus_rdata[PRE_W-1:0] = pre_q;
            A_PERIOD: bus_rdata[PER_W-1:0] = per_q;
            A_ALARM:  bus_rdata[CNT_W-1:0] = alm_q;
            A_COUNT:  bus_rdata[CNT_W-1:0] = cnt_q;
            A_STATUS: bus_rdata[ST_W-1:0]  = st_q;
            A_IMASK:  bus_rdata[ST_W-1:0]  = mask_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sst_timer_chk.sv
// Checker for the slow-clock system timer, bound to the top module.
// Assumes visibility of the count, status and mask registers of the top scope.
module sst_timer_chk #(
    parameter int CNT_W  = 20,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [2:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [3:0]        st_q,
    input logic [3:0]        mask_q,
    input logic              irq
);
    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 3'd5)
            |=> ((mask_q & $past(bus_wdata[3:0])) == $past(bus_wdata[3:0])));

    // R8
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 3'd6)
            |=> ((mask_q & $past(bus_wdata[3:0])) == 4'd0));

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 3'd4 && !tick_en) |=> (st_q == 4'd0));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 4'd0) |-> !irq);
endmodule

bind slow_sys_timer sst_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cnt_q(cnt_q), .st_q(st_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/slow_sys_timer_tb_top.sv
// Bench for the slow-clock system timer, run with an 8-bit count.
module slow_sys_timer_tb_top;
    localparam int CW = 8;
    localparam int WRAP = 1 << CW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_run = 0;
    int n_bad = 0;

    slow_sys_timer #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d, expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_en = 1'b1;
            @(negedge clk) tick_en = 1'b0;
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 v = int'(bus_rdata);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        int v, v2, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        rd(3'd0, v); chk("R2 divider reset", v, 32768);
        rd(3'd3, v); chk("R2 count reset", v, 0);
        rd(3'd4, v); chk("R2 status reset", v, 0);
        rd(3'd7, v); chk("R2 mask reset", v, 0);
        rd(3'd1, v); chk("R2 period reset", v, 0);
        rd(3'd2, v); chk("R2 alarm reset", v, 0);
        chk("R9 irq reset", int'(irq), 0);

        // R2 default divider, R6 increment bit
        tick(32767);
        rd(3'd3, v); chk("R2 no advance before 32768 ticks", v, 0);
        rd(3'd4, v); chk("R6 no increment bit yet", v, 0);
        tick(1);
        rd(3'd3, v); chk("R2 advance at 32768 ticks", v, 1);
        rd(3'd4, v); chk("R6 increment bit set", (v >> 2) & 1, 1);
        chk("R6 watchdog bit zero", (v >> 1) & 1, 0);

        // R3 divider sweep
        for (int p = 0; p <= 6; p++) begin
            int pe;
            pe = (p == 0) ? 1 : p;
            wr(3'd0, p);
            rd(3'd3, c);
            tick(pe - 1);
            rd(3'd3, v); chk($sformatf("R3 hold P=%0d", p), v, c);
            tick(1);
            rd(3'd3, v); chk($sformatf("R3 step P=%0d", p), v, (c + 1) % WRAP);
            tick(2 * pe);
            rd(3'd3, v); chk($sformatf("R3 three steps P=%0d", p), v, (c + 3) % WRAP);
        end

        // R1 wrap with divider 1
        wr(3'd0, 1);
        rd(3'd3, c);
        tick(WRAP - 1 - c);
        rd(3'd3, v); chk("R1 all ones", v, WRAP - 1);
        tick(1);
        rd(3'd3, v); chk("R1 wrap to zero", v, 0);

        // R10 back-to-back count reads
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd3;
        #1 v = int'(bus_rdata);
        @(negedge clk);
        #1 v2 = int'(bus_rdata);
        @(negedge clk) bus_sel = 1'b0;
        chk("R10 stable count", v2, v);

        // R5 alarm sweep, including alarm equal to current count
        for (int a = 0; a < WRAP; a += 17) begin
            int d;
            rd(3'd4, v);
            rd(3'd3, c);
            wr(3'd2, a);
            d = (a - c + WRAP) % WRAP;
            if (d == 0) d = WRAP;
            tick(d - 1);
            rd(3'd4, v); chk($sformatf("R5 early a=%0d", a), (v >> 3) & 1, 0);
            tick(1);
            rd(3'd4, v); chk($sformatf("R5 fire a=%0d", a), (v >> 3) & 1, 1);
            rd(3'd3, v); chk($sformatf("R5 count a=%0d", a), v, a);
        end
        rd(3'd3, c);
        wr(3'd2, c);
        tick(WRAP - 1);
        rd(3'd4, v); chk("R5 equal alarm quiet", (v >> 3) & 1, 0);
        tick(1);
        rd(3'd4, v); chk("R5 equal alarm after wrap", (v >> 3) & 1, 1);

        // R4 period sweep
        for (int p = 1; p <= 6; p++) begin
            wr(3'd1, p);
            rd(3'd4, v);
            for (int k = 0; k < 2; k++) begin
                if (p > 1) begin
                    tick(p - 1);
                    rd(3'd4, v); chk($sformatf("R4 early P=%0d", p), v & 1, 0);
                end
                tick(1);
                rd(3'd4, v); chk($sformatf("R4 expire P=%0d", p), v & 1, 1);
            end
        end
        wr(3'd1, 0);
        rd(3'd4, v);
        tick(10);
        rd(3'd4, v); chk("R4 period zero stops", v & 1, 0);

        // R7 clear on read, event in the read cycle survives
        rd(3'd4, v);
        rd(3'd4, v); chk("R7 second read empty", v, 0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'd4; tick_en = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; tick_en = 1'b0;
        rd(3'd4, v); chk("R7 same-cycle event kept", (v >> 2) & 1, 1);

        // R8 mask set/clear, R9 irq
        tick(1);
        chk("R9 irq low with mask zero", int'(irq), 0);
        wr(3'd5, 4);
        chk("R9 irq high with masked inc", int'(irq), 1);
        rd(3'd7, v); chk("R8 mask after set", v, 4);
        wr(3'd5, 8);
        rd(3'd7, v); chk("R8 mask accumulates", v, 12);
        wr(3'd6, 4);
        rd(3'd7, v); chk("R8 mask after clear", v, 8);
        chk("R9 irq low when pending unmasked", int'(irq), 0);
        rd(3'd4, v);
        chk("R9 irq low after clear", int'(irq), 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule